// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block keeps the per-vector state of a local interrupt controller for one core. Every vector has three flags: waiting (requested), being serviced, and level-triggered. Sources raise vectors through a valid/ready stream. The block finds the best waiting vector and compares its 16-vector priority class with a processor priority. That processor priority is the larger of the task priority and the class of the best vector in service. From this comparison the block drives a registered interrupt line to the core.

The core takes an interrupt through an acknowledge handshake. The reply is either the granted vector, which moves from waiting to in service in the same cycle, or the programmable spurious vector when nothing may be delivered. Software retires the best in-service vector with an end-of-interrupt pulse. A level-triggered vector retired this way is announced on a broadcast output, unless the suppress control is high. A small register port holds the task priority and the spurious/enable register, and reads back the processor priority.

Both streams have `*_ready` tied high. A raise or an acknowledge with its valid high at a rising edge is always taken in that cycle, and no back-pressure is ever applied. Results of an acknowledge are valid combinationally while `ack_valid` is high.

Top module: `irqv_ctrl`

## Requirements
- R1: Among waiting vectors, the highest-numbered one is the best; a granted acknowledge returns it on `ack_vec` with `ack_spur` low.
- R2: Processor priority (read with `reg_sel`=2) equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector; otherwise it is that nibble followed by four zeros. No in-service vector counts as vector 0. Writes with `reg_sel`=2 have no effect.
- R3: When bit 8 of the spurious register is 0, or nothing is waiting, `irq` is low and an acknowledge returns the spurious register's low 8 bits with `ack_spur` high.
- R4: When processor priority is nonzero and the best waiting vector's upper nibble is at most its upper nibble, an acknowledge returns the spurious register's low 8 bits with `ack_spur` high, and the in-service set does not change.
- R5: A granted acknowledge clears the vector's waiting flag and sets its in-service flag at the same clock edge.
- R6: A raise sets the vector's waiting flag. Its level flag is set when `raise_level`=1 and cleared when `raise_level`=0. `raise_new` is high during a raise only when the vector was not already waiting.
- R7: An `eoi_we` pulse clears the highest in-service vector. One cycle later, `eoi_bcast_valid` is high with that vector on `eoi_bcast_vec` only if its level flag was set and `eoi_suppress` was low.
- R8: Reset leaves task priority at 0x00 and the spurious register at 0x0FF. A write with `reg_sel`=0 keeps data bits 7:0 as task priority. A write with `reg_sel`=1 keeps bits 8:0 as the spurious register.
- R9: An acknowledge in the same cycle as an end-of-interrupt is judged against the in-service set after that end-of-interrupt.
- R10: `irq` is a register: it reflects the state present at the previous clock edge, so a state change shows on `irq` one cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_valid | input | 1 | Raise a vector |
| raise_ready | output | 1 | Always 1 |
| raise_vec | input | 8 | Vector to raise |
| raise_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| raise_new | output | 1 | Raised vector was not already waiting |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 task priority, 1 spurious/enable, 2 processor priority (read only) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel`, zero-extended |
| ack_valid | input | 1 | Acknowledge request from the core |
| ack_ready | output | 1 | Always 1 |
| ack_vec | output | 8 | Granted or spurious vector |
| ack_spur | output | 1 | Reply is the spurious vector |
| eoi_we | input | 1 | End-of-interrupt pulse |
| eoi_suppress | input | 1 | Block the end-of-interrupt broadcast |
| eoi_bcast_valid | output | 1 | Broadcast of a retired level vector |
| eoi_bcast_vec | output | 8 | Retired vector being broadcast |
| irq | output | 1 | Registered interrupt request to the core |

## Verification
An end-of-interrupt and an acknowledge can arrive in the same cycle, and their order decides whether the acknowledge is blocked. The bench sets up a case where it matters: vector 0x90 is in service and 0x85 is waiting, so 0x85 is blocked on its own. It then pulses `eoi_we` and `ack_valid` together. The reply must be the grant of 0x85, not the spurious vector, and the processor priority read afterwards must be 0x80. That shows 0x90 was retired and 0x85 moved into service at the same edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    SEL_TASK = 2'd0,
    SEL_SPUR = 2'd1,
    SEL_PROC = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CLS_BITS = 4;
endpackage

// File: rtl/irqv_msb_find.sv
module irqv_msb_find #(
  parameter int unsigned N    = 256,
  parameter int unsigned WORD = 32,
  localparam int unsigned W   = $clog2(N),
  localparam int unsigned WB  = $clog2(WORD),
  localparam int unsigned NW  = N / WORD
) (
  input  logic [N-1:0] bits,
  output logic         any,
  output logic [W-1:0] idx
);
  logic [NW-1:0] w_any;
  logic [WB-1:0] w_idx [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [WB-1:0] lidx;
    always_comb begin
      lidx = '0;
      for (int b = 0; b < WORD; b++) begin
        if (bits[g*WORD + b]) lidx = WB'(b);
      end
    end
    assign w_any[g] = |bits[g*WORD +: WORD];
    assign w_idx[g] = lidx;
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int w = 0; w < NW; w++) begin
      if (w_any[w]) begin
        any = 1'b1;
        idx = W'(w * WORD) | W'(w_idx[w]);
      end
    end
  end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
  import irqv_pkg::*;
#(
  parameter int unsigned VW = 8
) (
  input  logic          enable,
  input  logic          req_any,
  input  logic [VW-1:0] req_top,
  input  logic          isr_any,
  input  logic [VW-1:0] isr_top,
  input  logic [VW-1:0] tpr,
  output logic [VW-1:0] ppr,
  output logic          deliver
);
  localparam int unsigned HI = VW - 1;

  logic [CLS_BITS-1:0] isr_cls;
  logic                blocked;

  always_comb begin
    isr_cls = isr_any ? isr_top[HI -: CLS_BITS] : '0;
    if (tpr[HI -: CLS_BITS] >= isr_cls) ppr = tpr;
    else                                ppr = {isr_cls, {(VW-CLS_BITS){1'b0}}};
    blocked = (ppr != '0) && (req_top[HI -: CLS_BITS] <= ppr[HI -: CLS_BITS]);
    deliver = enable && req_any && !blocked;
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned NVEC = 256,
  parameter int unsigned DW   = 32,
  localparam int unsigned VW  = $clog2(NVEC),
  localparam int unsigned HI  = VW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raise_valid,
  output logic          raise_ready,
  input  logic [VW-1:0] raise_vec,
  input  logic          raise_level,
  output logic          raise_new,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ack_valid,
  output logic          ack_ready,
  output logic [VW-1:0] ack_vec,
  output logic          ack_spur,
  input  logic          eoi_we,
  input  logic          eoi_suppress,
  output logic          eoi_bcast_valid,
  output logic [VW-1:0] eoi_bcast_vec,
  output logic          irq
);
  logic [NVEC-1:0] req_q, isr_q, tmr_q;
  logic [NVEC-1:0] req_n, isr_n, tmr_n, isr_post;
  logic [VW-1:0]   tpr_q;
  logic [VW:0]     svr_q;
  logic            bcast_q;
  logic [VW-1:0]   bvec_q;
  logic            irq_q;

  logic          req_any, isr_any, post_any;
  logic [VW-1:0] req_top, isr_top, post_top;
  logic [VW-1:0] ppr_now, ppr_post;
  logic          deliver_now, deliver_post;
  logic          eoi_hit, ack_ok;
  reg_sel_e      sel;
  logic          unused_wdata;

  assign sel          = reg_sel_e'(reg_sel);
  assign unused_wdata = ^reg_wdata[DW-1:VW+1];
  assign raise_ready  = 1'b1;
  assign ack_ready    = 1'b1;

  irqv_msb_find #(.N(NVEC)) u_find_req  (.bits(req_q),    .any(req_any),  .idx(req_top));
  irqv_msb_find #(.N(NVEC)) u_find_isr  (.bits(isr_q),    .any(isr_any),  .idx(isr_top));
  irqv_msb_find #(.N(NVEC)) u_find_post (.bits(isr_post), .any(post_any), .idx(post_top));

  // priority seen by the core now (drives irq and readback)
  irqv_prio #(.VW(VW)) u_prio_now (
    .enable(svr_q[VW]), .req_any(req_any), .req_top(req_top),
    .isr_any(isr_any), .isr_top(isr_top), .tpr(tpr_q),
    .ppr(ppr_now), .deliver(deliver_now)
  );

  // priority after this cycle's EOI (drives the acknowledge)
  irqv_prio #(.VW(VW)) u_prio_post (
    .enable(svr_q[VW]), .req_any(req_any), .req_top(req_top),
    .isr_any(post_any), .isr_top(post_top), .tpr(tpr_q),
    .ppr(ppr_post), .deliver(deliver_post)
  );

  assign eoi_hit   = eoi_we && isr_any;
  assign ack_ok    = ack_valid && deliver_post;
  assign ack_vec   = deliver_post ? req_top : svr_q[HI:0];
  assign ack_spur  = !deliver_post;
  assign raise_new = raise_valid && !req_q[raise_vec];

  always_comb begin
    isr_post = isr_q;
    if (eoi_hit) isr_post[isr_top] = 1'b0;
    isr_n = isr_post;
    req_n = req_q;
    tmr_n = tmr_q;
    if (ack_ok) begin
      req_n[req_top] = 1'b0;
      isr_n[req_top] = 1'b1;
    end
    if (raise_valid) begin
      req_n[raise_vec] = 1'b1;
      tmr_n[raise_vec] = raise_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      isr_q   <= '0;
      tmr_q   <= '0;
      tpr_q   <= '0;
      svr_q   <= {1'b0, {VW{1'b1}}};
      bcast_q <= 1'b0;
      bvec_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      req_q   <= req_n;
      isr_q   <= isr_n;
      tmr_q   <= tmr_n;
      bcast_q <= eoi_hit && tmr_q[isr_top] && !eoi_suppress;
      bvec_q  <= isr_top;
      irq_q   <= deliver_now;
      if (reg_we && sel == SEL_TASK) tpr_q <= reg_wdata[HI:0];
      if (reg_we && sel == SEL_SPUR) svr_q <= reg_wdata[VW:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_TASK: reg_rdata = DW'(tpr_q);
      SEL_SPUR: reg_rdata = DW'(svr_q);
      SEL_PROC: reg_rdata = DW'(ppr_now);
      default:  reg_rdata = '0;
    endcase
  end

  assign eoi_bcast_valid = bcast_q;
  assign eoi_bcast_vec   = bvec_q;
  assign irq             = irq_q;

  p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_now[HI -: CLS_BITS] >= tpr_q[HI -: CLS_BITS]);

  p_irq_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(svr_q[VW]));

  p_spur_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_spur && !eoi_we) |=> $stable(isr_q));

  p_ack_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_spur && !(raise_valid && raise_vec == ack_vec))
    |=> (isr_q[$past(ack_vec)] && !req_q[$past(ack_vec)]));

  p_raise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raise_valid |=> req_q[$past(raise_vec)]);

  p_bcast_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> ($past(eoi_we) && !$past(eoi_suppress)));
endmodule

// File: tb/irqv_ctrl_bench.sv
module irqv_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        raise_valid, raise_level, raise_ready, raise_new;
  logic [7:0]  raise_vec;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ack_valid, ack_ready, ack_spur;
  logic [7:0]  ack_vec;
  logic        eoi_we, eoi_suppress, eoi_bcast_valid;
  logic [7:0]  eoi_bcast_vec;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irqv_ctrl u_irqv_ctrl (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_ready(raise_ready), .raise_vec(raise_vec),
    .raise_level(raise_level), .raise_new(raise_new),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_vec(ack_vec), .ack_spur(ack_spur),
    .eoi_we(eoi_we), .eoi_suppress(eoi_suppress),
    .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    raise_valid = 0; reg_we = 0; ack_valid = 0; eoi_we = 0; eoi_suppress = 0;
  endtask

  task automatic raise(input logic [7:0] v, input logic lvl, input logic exp_new, input string tag);
    raise_valid = 1; raise_vec = v; raise_level = lvl;
    #1 chk(tag, raise_new, exp_new);
    step(); idle();
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    step(); idle();
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
    reg_sel = s;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic ack(input logic [7:0] exp_vec, input logic exp_spur, input string tag);
    ack_valid = 1;
    #1 chk({tag, " vec"}, ack_vec, exp_vec);
    chk({tag, " spur"}, ack_spur, exp_spur);
    step(); idle();
  endtask

  task automatic eoi(input logic sup, input logic exp_b, input logic [7:0] exp_v, input string tag);
    eoi_we = 1; eoi_suppress = sup;
    step(); idle();
    chk({tag, " bcast"}, eoi_bcast_valid, exp_b);
    if (exp_b) chk({tag, " bvec"}, eoi_bcast_vec, exp_v);
  endtask

  task automatic t_reset();
    rd(2'd0, 32'h00, "R8 reset tpr");
    rd(2'd1, 32'h0FF, "R8 reset svr");
    rd(2'd2, 32'h00, "R2 reset ppr");
    chk("R10 reset irq", irq, 0);
    chk("R7 reset bcast", eoi_bcast_valid, 0);
  endtask

  task automatic t_disabled();
    raise(8'h45, 0, 1, "R6 new raise");
    step();
    chk("R3 irq disabled", irq, 0);
    ack(8'hFF, 1, "R3 ack disabled");
  endtask

  task automatic t_enable();
    wr(2'd1, 32'hFFFF_F13F);
    rd(2'd1, 32'h13F, "R8 svr low9");
    chk("R10 irq lag", irq, 0);
    step();
    chk("R10 irq rises", irq, 1);
  endtask

  task automatic t_order();
    raise(8'h80, 0, 1, "R6 raise 80");
    raise(8'h21, 1, 1, "R6 raise 21");
    raise(8'h80, 0, 0, "R6 re-raise 80");
    ack(8'h80, 0, "R1 best is 80");
    rd(2'd2, 32'h80, "R2 ppr from isr");
    ack(8'h3F, 1, "R4 blocked by isr");
    rd(2'd2, 32'h80, "R4 isr unchanged");
    eoi(0, 0, 8'h00, "R7 edge no bcast");
    rd(2'd2, 32'h00, "R7 isr retired");
    ack(8'h45, 0, "R5 grant 45");
    rd(2'd2, 32'h40, "R5 45 in service");
    wr(2'd0, 32'hFFFF_FF5A);
    rd(2'd0, 32'h5A, "R8 tpr low8");
    rd(2'd2, 32'h5A, "R2 ppr is tpr");
    ack(8'h3F, 1, "R4 blocked by tpr");
    wr(2'd0, 32'h37);
    rd(2'd2, 32'h40, "R2 ppr isr wins");
    wr(2'd2, 32'hFF);
    rd(2'd2, 32'h40, "R2 ppr write ignored");
    wr(2'd0, 32'h00);
    eoi(0, 0, 8'h00, "R7 retire 45");
    ack(8'h21, 0, "R5 45 left request");
    eoi(0, 1, 8'h21, "R7 level bcast");
    step();
    chk("R7 bcast one cycle", eoi_bcast_valid, 0);
    chk("R3 irq empty", irq, 0);
    ack(8'h3F, 1, "R3 ack empty");
  endtask

  task automatic t_trigger();
    raise(8'h33, 1, 1, "R6 raise 33");
    ack(8'h33, 0, "R5 grant 33");
    eoi(1, 0, 8'h00, "R7 suppressed");
    raise(8'h66, 1, 1, "R6 raise 66 level");
    raise(8'h66, 0, 0, "R6 raise 66 edge");
    ack(8'h66, 0, "R5 grant 66");
    eoi(0, 0, 8'h00, "R6 edge cleared level");
  endtask

  task automatic t_same_cycle();
    raise(8'h90, 0, 1, "R6 raise 90");
    ack(8'h90, 0, "R1 grant 90");
    raise(8'h85, 0, 1, "R6 raise 85");
    ack(8'h3F, 1, "R4 85 blocked");
    eoi_we = 1; ack_valid = 1;
    #1 chk("R9 eoi first vec", ack_vec, 8'h85);
    chk("R9 eoi first spur", ack_spur, 0);
    step(); idle();
    rd(2'd2, 32'h80, "R9 85 in service");
    eoi(0, 0, 8'h00, "R7 retire 85");
    rd(2'd2, 32'h00, "R7 isr empty");
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); raise_vec = 0; raise_level = 0; reg_sel = 0; reg_wdata = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_disabled();
    t_enable();
    t_order();
    t_trigger();
    t_same_cycle();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule